// File: doc/BRIEF.md
# UART Modem Control and Interrupt Unit

This unit is the processor-facing front end of a small asynchronous serial port. It decodes a two-bit register address with chip select and read/write enables into one-cycle strobes for the neighbouring transmit buffer, receive buffer, line-format and rate registers. It also holds the modem control register, which drives the active-low request-to-send and terminal-ready lines and sets the interrupt enables, the receiver enable and the operating mode. It keeps the three line-status flags, and it builds a modem status byte from the clear-to-send and data-set-ready inputs, with a change latch on each line.

The shift registers and the rate generator sit outside this unit. The unit tells the transmitter when it may shift. It chooses what reaches the serial output pin and what reaches the receiver input in each of four modes: normal, line break, echo and internal loop. A single interrupt line combines data-ready with the modem-change flags. A master enable gates the whole line, and a second enable gates the modem-change part.

Top module: `uart_modem_ctrl`

## Requirements
- R1: With `csN` low and exactly one of `rdEn`/`wrEn` high, address 0 gives `txBufWr` on write and `rxBufRd` on read, and address 1 gives `ctrlWr` on write. Address 3 gives `baudWr` on write. With `csN` high, or with both enables high, no strobe fires and `rdata` is 0.
- R2: The read mux returns `rxBufData` at address 0, the status byte at 1, the modem control register at 2 and the modem status byte at 3.
- R3: The modem control register has this layout: bit 0 request-to-send on, bit 1 terminal-ready on, bit 2 master interrupt enable, bit 3 modem-change interrupt enable, bit 4 receiver enable, bits 6:5 mode (0 normal, 1 break, 2 echo, 3 loop). Bit 7 always reads 0. A write at address 2 loads it and reset clears it.
- R4: `rtsN` is low exactly when MCR bit 0 is 1, and `dtrN` is low exactly when MCR bit 1 is 1. Both are high after reset.
- R5: The status byte is laid out as bit 0 data-ready, bit 1 holding-empty and bit 2 transmission-complete, with the upper bits 0. Reset gives 0b110. The flags are updated as follows:
  - `rxCharDone` sets data-ready.
  - A transmit-buffer write clears holding-empty.
  - `txBufTaken` sets holding-empty and clears transmission-complete.
  - `txShiftDone` sets transmission-complete.
- R6: A receive-buffer read clears data-ready on the next clock, unless `rxCharDone` arrives in the same cycle.
- R7: The modem status byte is laid out as bit 0 CTS true, bit 1 DSR true, bit 2 CTS changed and bit 3 DSR changed. The line levels pass through a two-flop synchroniser. Any edge of a synchronised line sets its change bit.
- R8: Reading the modem status byte clears both change bits on the next clock, unless a new edge arrives in that cycle.
- R9: `intr` = master enable AND (data-ready OR (modem-change enable AND any change bit)). It is low whenever the master enable is 0.
- R10: In normal mode, `sdoPin` = `txSerial` and `txEnable` follows CTS true. `rxSerial` = `sdiPin` when the receiver is enabled and 1 (mark) otherwise.
- R11: In break mode, `sdoPin` is 0 and `txEnable` is 0. The receiver path is as in normal mode.
- R12: In echo mode, `sdoPin` follows `sdiPin` combinationally with no register in the path, and `txEnable` is 0. The receiver path is as in normal mode.
- R13: In loop mode, `rxSerial` = `txSerial`, `sdoPin` holds mark (1), and `txEnable` is 1 whatever the CTS level or `sdiPin` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdEn | input | 1 | Read enable for this cycle |
| wrEn | input | 1 | Write enable for this cycle |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read |
| txBufWr | output | 1 | Strobe: load transmit buffer from `wdata` |
| ctrlWr | output | 1 | Strobe: load line-format register from `wdata` |
| baudWr | output | 1 | Strobe: load rate-select register from `wdata` |
| rxBufRd | output | 1 | Strobe: receive buffer is being read |
| rxBufData | input | 8 | Receive buffer contents |
| rxCharDone | input | 1 | Pulse: a character reached the receive buffer |
| txBufTaken | input | 1 | Pulse: transmit buffer moved into the shifter |
| txShiftDone | input | 1 | Pulse: shifter finished its last stop bit |
| dataReady | output | 1 | Data-ready flag |
| holdEmpty | output | 1 | Holding-empty flag |
| ctsN | input | 1 | Clear-to-send, active low |
| dsrN | input | 1 | Data-set-ready, active low |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Terminal-ready, active low |
| intr | output | 1 | Interrupt request, active high |
| sdiPin | input | 1 | External serial input |
| sdoPin | output | 1 | External serial output |
| txSerial | input | 1 | Serial bit from the transmit shifter |
| rxSerial | output | 1 | Serial bit to the receive shifter |
| txEnable | output | 1 | Transmit shifter may start or continue |

## Verification
Four things are checked on every cycle. At most one strobe fires at a time. The interrupt stays low while the master enable is off. A receive-buffer read or a status read with no competing set event clears its flags one clock later. The reset values of the modem lines and status flags hold on the clock after reset. The bench sweeps cover the remaining behaviour: every address/direction/select combination, all 256 modem control writes with readback and pin levels, and the two-flop latency and change latching of the modem lines. They also cover the interrupt composition and the full matrix of mode × receiver enable × CTS × serial input × shifter output for the routing.

// File: rtl/umc_pkg.sv
package umc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODEM = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_LINES = 2'd3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_BREAK  = 2'd1,
    MODE_ECHO   = 2'd2,
    MODE_LOOP   = 2'd3
  } opMode_e;

  // One-cycle access strobes produced by the decoder.
  typedef struct packed {
    logic txBufWr;
    logic ctrlWr;
    logic mcrWr;
    logic baudWr;
    logic rxBufRd;
    logic statRd;
    logic mcrRd;
    logic msrRd;
  } busStb_t;

  // Modem control register layout, bit 7 down to bit 0.
  typedef struct packed {
    logic    reserved;
    opMode_e mode;
    logic    rxEn;
    logic    modemIntEn;
    logic    intEn;
    logic    dtrOn;
    logic    rtsOn;
  } mcr_t;
endpackage

// File: rtl/umc_bus_decode.sv
module umc_bus_decode
  import umc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output busStb_t           stb
);
  logic doRd, doWr;

  // A cycle with both enables high is treated as no access.
  assign doRd = !csN && rdEn && !wrEn;
  assign doWr = !csN && wrEn && !rdEn;

  always_comb begin
    stb = '0;
    unique case (addr)
      ADDR_DATA:  begin stb.txBufWr = doWr; stb.rxBufRd = doRd; end
      ADDR_CTRL:  begin stb.ctrlWr  = doWr; stb.statRd  = doRd; end
      ADDR_MODEM: begin stb.mcrWr   = doWr; stb.mcrRd   = doRd; end
      default:    begin stb.baudWr  = doWr; stb.msrRd   = doRd; end
    endcase
  end

  // R1
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    csN |-> (stb == '0));
endmodule

// File: rtl/umc_modem_dp.sv
module umc_modem_dp
  import umc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  busStb_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rxBufData,
  input  logic              rxCharDone,
  input  logic              txBufTaken,
  input  logic              txShiftDone,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              sdiPin,
  input  logic              txSerial,
  output logic [DATA_W-1:0] rdata,
  output logic              rtsN,
  output logic              dtrN,
  output logic              intr,
  output logic              sdoPin,
  output logic              rxSerial,
  output logic              txEnable,
  output logic              dataReady,
  output logic              holdEmpty
);
  localparam int N_LINES = 2;   // index 0: clear-to-send, 1: data-set-ready
  localparam int PAD_STAT = DATA_W - 3;
  localparam int PAD_MSR  = DATA_W - 2 * N_LINES;

  mcr_t mcr;
  logic txComplete;
  logic [N_LINES-1:0] lineN, lineTrue, lineLast, lineEdge, lineChg;
  logic anyChg;

  // ---------------- modem control register ----------------
  always_ff @(posedge clk) begin
    if (rst) mcr <= '0;
    else if (stb.mcrWr) begin
      mcr          <= mcr_t'(wdata);
      mcr.reserved <= 1'b0;
    end
  end

  assign rtsN = !mcr.rtsOn;
  assign dtrN = !mcr.dtrOn;

  // ---------------- line status flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dataReady  <= 1'b0;
      holdEmpty  <= 1'b1;
      txComplete <= 1'b1;
    end else begin
      if (rxCharDone)       dataReady <= 1'b1;
      else if (stb.rxBufRd) dataReady <= 1'b0;
      if (stb.txBufWr)      holdEmpty <= 1'b0;
      else if (txBufTaken)  holdEmpty <= 1'b1;
      if (txShiftDone)      txComplete <= 1'b1;
      else if (txBufTaken)  txComplete <= 1'b0;
    end
  end

  // ---------------- modem line sync and change latch ----------------
  assign lineN = {dsrN, ctsN};

  for (genvar g = 0; g < N_LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], !lineN[g]};
    end
    assign lineTrue[g] = chain[SYNC_STAGES-1];
  end

  assign lineEdge = lineTrue ^ lineLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineLast <= '0;
      lineChg  <= '0;
    end else begin
      lineLast <= lineTrue;
      lineChg  <= (lineChg & ~{N_LINES{stb.msrRd}}) | lineEdge;
    end
  end

  assign anyChg = |lineChg;

  // ---------------- interrupt ----------------
  assign intr = mcr.intEn && (dataReady || (mcr.modemIntEn && anyChg));

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    if (stb.rxBufRd)     rdata = rxBufData;
    else if (stb.statRd) rdata = {{PAD_STAT{1'b0}}, txComplete, holdEmpty, dataReady};
    else if (stb.mcrRd)  rdata = DATA_W'(mcr);
    else if (stb.msrRd)  rdata = {{PAD_MSR{1'b0}}, lineChg[1], lineChg[0], lineTrue[1], lineTrue[0]};
  end

  // ---------------- serial path routing ----------------
  always_comb begin
    rxSerial = mcr.rxEn ? sdiPin : 1'b1;
    sdoPin   = 1'b1;
    txEnable = 1'b0;
    unique case (mcr.mode)
      MODE_NORMAL: begin sdoPin = txSerial; txEnable = lineTrue[0]; end
      MODE_BREAK:  sdoPin = 1'b0;
      MODE_ECHO:   sdoPin = sdiPin;
      default:     begin rxSerial = txSerial; txEnable = 1'b1; end
    endcase
  end

  // R4 R5
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rtsN && dtrN && holdEmpty && txComplete && !dataReady));

  // R9
  intr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mcr.intEn |-> !intr);

  // R6
  rx_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.rxBufRd && !rxCharDone) |=> !dataReady);

  // R8
  msr_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.msrRd && !(|lineEdge)) |=> (lineChg == '0));

  // R11
  break_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mcr.mode == MODE_BREAK) |-> (!sdoPin && !txEnable));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import umc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              txBufWr,
  output logic              ctrlWr,
  output logic              baudWr,
  output logic              rxBufRd,
  input  logic [DATA_W-1:0] rxBufData,
  input  logic              rxCharDone,
  input  logic              txBufTaken,
  input  logic              txShiftDone,
  output logic              dataReady,
  output logic              holdEmpty,
  input  logic              ctsN,
  input  logic              dsrN,
  output logic              rtsN,
  output logic              dtrN,
  output logic              intr,
  input  logic              sdiPin,
  output logic              sdoPin,
  input  logic              txSerial,
  output logic              rxSerial,
  output logic              txEnable
);
  busStb_t stb;

  umc_bus_decode decode_i (
    .clk  (clk),
    .rst  (rst),
    .csN  (csN),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  umc_modem_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .wdata       (wdata),
    .rxBufData   (rxBufData),
    .rxCharDone  (rxCharDone),
    .txBufTaken  (txBufTaken),
    .txShiftDone (txShiftDone),
    .ctsN        (ctsN),
    .dsrN        (dsrN),
    .sdiPin      (sdiPin),
    .txSerial    (txSerial),
    .rdata       (rdata),
    .rtsN        (rtsN),
    .dtrN        (dtrN),
    .intr        (intr),
    .sdoPin      (sdoPin),
    .rxSerial    (rxSerial),
    .txEnable    (txEnable),
    .dataReady   (dataReady),
    .holdEmpty   (holdEmpty)
  );

  assign txBufWr = stb.txBufWr;
  assign ctrlWr  = stb.ctrlWr;
  assign baudWr  = stb.baudWr;
  assign rxBufRd = stb.rxBufRd;
endmodule

// File: tb/uart_modem_ctrl_tb_top.sv
module uart_modem_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1, rdEn = 1'b0, wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rxBufData = 8'hA5;
  logic       txBufWr, ctrlWr, baudWr, rxBufRd;
  logic       rxCharDone = 1'b0, txBufTaken = 1'b0, txShiftDone = 1'b0;
  logic       dataReady, holdEmpty;
  logic       ctsN = 1'b1, dsrN = 1'b1, rtsN, dtrN, intr;
  logic       sdiPin = 1'b1, sdoPin, txSerial = 1'b1, rxSerial, txEnable;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_ctrl dut_i (
    .clk(clk), .rst(rst), .csN(csN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txBufWr(txBufWr), .ctrlWr(ctrlWr),
    .baudWr(baudWr), .rxBufRd(rxBufRd), .rxBufData(rxBufData),
    .rxCharDone(rxCharDone), .txBufTaken(txBufTaken), .txShiftDone(txShiftDone),
    .dataReady(dataReady), .holdEmpty(holdEmpty), .ctsN(ctsN), .dsrN(dsrN),
    .rtsN(rtsN), .dtrN(dtrN), .intr(intr), .sdiPin(sdiPin), .sdoPin(sdoPin),
    .txSerial(txSerial), .rxSerial(rxSerial), .txEnable(txEnable)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrEn = 1'b1; rdEn = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    csN = 1'b1; wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdEn = 1'b1; wrEn = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    csN = 1'b1; rdEn = 1'b0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    rxCharDone  = (which == 0);
    txBufTaken  = (which == 1);
    txShiftDone = (which == 2);
    @(negedge clk);
    rxCharDone = 1'b0; txBufTaken = 1'b0; txShiftDone = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R4 reset levels, R5 reset status, R3 cleared register
    @(negedge clk);
    check("R4 rtsN reset", {7'b0, rtsN}, 8'h01);
    check("R4 dtrN reset", {7'b0, dtrN}, 8'h01);
    check("R9 intr reset", {7'b0, intr}, 8'h00);
    busRead(2'd1, rd); check("R5 status reset", rd, 8'h06);
    busRead(2'd2, rd); check("R3 mcr reset", rd, 8'h00);

    // R1 decode sweep over select, address and direction
    for (int cs = 0; cs < 2; cs++)
      for (int a = 0; a < 4; a++)
        for (int dir = 0; dir < 3; dir++) begin
          logic r, w;
          @(negedge clk);
          r = (dir != 1); w = (dir != 0);
          csN = cs[0]; rdEn = r; wrEn = w; addr = a[1:0]; wdata = 8'h00;
          #1;
          check("R1 txBufWr", {7'b0, txBufWr}, {7'b0, (cs == 0 && dir == 1 && a == 0)});
          check("R1 rxBufRd", {7'b0, rxBufRd}, {7'b0, (cs == 0 && dir == 0 && a == 0)});
          check("R1 ctrlWr",  {7'b0, ctrlWr},  {7'b0, (cs == 0 && dir == 1 && a == 1)});
          check("R1 baudWr",  {7'b0, baudWr},  {7'b0, (cs == 0 && dir == 1 && a == 3)});
          if (cs == 1 || dir == 2) check("R1 quiet rdata", rdata, 8'h00);
          @(negedge clk);
          csN = 1'b1; rdEn = 1'b0; wrEn = 1'b0;
        end
    doReset();

    // R2 data read returns receive buffer
    rxBufData = 8'h3C;
    busRead(2'd0, rd); check("R2 rx data read", rd, 8'h3C);

    // R3 R4 full sweep of modem control writes
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd2, v[7:0]);
      busRead(2'd2, rd);
      check("R3 mcr readback", rd, v[7:0] & 8'h7F);
      check("R4 rtsN level", {7'b0, rtsN}, {7'b0, !v[0]});
      check("R4 dtrN level", {7'b0, dtrN}, {7'b0, !v[1]});
    end
    busWrite(2'd2, 8'h04);   // master enable only

    // R5 R6 R9 data-ready path
    check("R9 idle intr", {7'b0, intr}, 8'h00);
    pulse(0);
    check("R5 dataReady set", {7'b0, dataReady}, 8'h01);
    check("R9 intr from data", {7'b0, intr}, 8'h01);
    busRead(2'd0, rd);
    check("R6 dataReady clear", {7'b0, dataReady}, 8'h00);
    check("R9 intr drops", {7'b0, intr}, 8'h00);
    busWrite(2'd0, 8'h55);
    busRead(2'd1, rd); check("R5 holdEmpty cleared", rd, 8'h04);
    pulse(1);
    busRead(2'd1, rd); check("R5 taken", rd, 8'h02);
    pulse(2);
    busRead(2'd1, rd); check("R5 shift done", rd, 8'h06);
    busWrite(2'd2, 8'h00);
    pulse(0);
    check("R9 master off", {7'b0, intr}, 8'h00);
    busRead(2'd0, rd);

    // R7 R8 R9 modem lines
    busWrite(2'd2, 8'h0C);
    @(negedge clk); ctsN = 1'b0;
    repeat (4) @(negedge clk);
    busRead(2'd3, rd); check("R7 cts change", rd, 8'h05);
    check("R8 changes cleared intr", {7'b0, intr}, 8'h00);
    busRead(2'd3, rd); check("R8 after clear", rd, 8'h01);
    @(negedge clk); dsrN = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 modem intr", {7'b0, intr}, 8'h01);
    busRead(2'd3, rd); check("R7 dsr change", rd, 8'h0B);
    busWrite(2'd2, 8'h04);
    @(negedge clk); ctsN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 modem enable off", {7'b0, intr}, 8'h00);
    busRead(2'd3, rd); check("R7 cts release", rd, 8'h06);
    @(negedge clk); dsrN = 1'b1;
    repeat (4) @(negedge clk);
    busRead(2'd3, rd);

    // R10 R11 R12 R13 routing matrix
    for (int m = 0; m < 4; m++)
      for (int re = 0; re < 2; re++) begin
        busWrite(2'd2, 8'((m << 5) | (re << 4)));
        for (int c = 0; c < 2; c++) begin
          @(negedge clk); ctsN = !c[0];
          repeat (3) @(negedge clk);
          for (int s = 0; s < 2; s++)
            for (int t = 0; t < 2; t++) begin
              logic eSdo, eRx, eEn;
              @(negedge clk); sdiPin = s[0]; txSerial = t[0];
              #1;
              eRx = re[0] ? s[0] : 1'b1;
              case (m)
                0: begin eSdo = t[0]; eEn = c[0]; end
                1: begin eSdo = 1'b0; eEn = 1'b0; end
                2: begin eSdo = s[0]; eEn = 1'b0; end
                default: begin eSdo = 1'b1; eEn = 1'b1; eRx = t[0]; end
              endcase
              if (m == 0) begin
                check("R10 sdo", {7'b0, sdoPin}, {7'b0, eSdo});
                check("R10 rx", {7'b0, rxSerial}, {7'b0, eRx});
                check("R10 txEnable", {7'b0, txEnable}, {7'b0, eEn});
              end else if (m == 1) begin
                check("R11 sdo", {7'b0, sdoPin}, {7'b0, eSdo});
                check("R11 rx", {7'b0, rxSerial}, {7'b0, eRx});
                check("R11 txEnable", {7'b0, txEnable}, {7'b0, eEn});
              end else if (m == 2) begin
                check("R12 sdo", {7'b0, sdoPin}, {7'b0, eSdo});
                check("R12 rx", {7'b0, rxSerial}, {7'b0, eRx});
                check("R12 txEnable", {7'b0, txEnable}, {7'b0, eEn});
              end else begin
                check("R13 sdo", {7'b0, sdoPin}, {7'b0, eSdo});
                check("R13 rx", {7'b0, rxSerial}, {7'b0, eRx});
                check("R13 txEnable", {7'b0, txEnable}, {7'b0, eEn});
              end
            end
        end
      end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule